// File: doc/BRIEF.md
# Video Address Decoder with Nametable Mirroring

This block sits between a video renderer's memory port and the memories behind it. The requester presents an address, a read or write strobe and write data. The block sends pattern-space traffic to the cartridge. Nametable traffic goes to an internal 2 KiB RAM, and palette traffic goes to an internal 32-entry RAM. Read data returns one clock after the read strobe, whichever target served it.

The cartridge supplies a 3-bit mirroring mode. This mode selects how the four logical 1 KiB nametable quadrants fold onto the physical RAM pages. The palette RAM folds the four sprite backdrop entries onto the matching background backdrop entries, so both views refer to the same storage.

Top module: `vmem_decoder`

## Requirements
- R1: Only `addr_i[13:0]` is decoded. Bits 15 and 14 are ignored, so 0xC123 behaves exactly like 0x0123.
- R2: Addresses 0x0000 to 0x1FFF go to the cartridge. In the strobe cycle `cart_rd_o` or `cart_wr_o` is high, `cart_addr_o` equals `addr_i[12:0]` and `cart_wdata_o` equals `wdata_i`. Neither internal RAM write strobe is raised.
- R3: For a cartridge read, `cart_rdata_i` is captured at the clock edge that ends the strobe cycle. It appears on `rdata_o` after that edge.
- R4: Addresses 0x3F00 to 0x3FFF select the palette RAM. The index is `addr_i[4:0]`, so 0x3FE5 reaches the same entry as 0x3F05.
- R5: A palette index of 0x10, 0x14, 0x18 or 0x1C is reduced by 0x10 on both reads and writes. No other index is changed, so for example 0x11 and 0x01 stay distinct.
- R6: Every other address from 0x2000 up selects the nametable RAM, with offset `addr_i[11:0]`. As a result, 0x3000 to 0x3EFF reach the same cells as 0x2000 to 0x2EFF.
- R7: The quadrant `offset[11:10]` maps to a page as follows. Mode 0 gives 0,0,1,1. Mode 1 gives 0,1,0,1. Mode 2 gives 0 for all quadrants. Mode 3 gives 1 for all quadrants. Mode 4 gives 0,1,2,3. The RAM index `nt_addr_o` is `{page[0], offset[9:0]}`, which means pages 2 and 3 wrap onto pages 0 and 1.
- R8: Mode values 5, 6 and 7 behave exactly like mode 0.
- R9: Internal RAM reads have one cycle of latency, like cartridge reads. `rdata_o` holds its value in every cycle that follows a cycle with no read strobe.
- R10: After reset `rdata_o` is 0. With no strobe active, `cart_rd_o`, `cart_wr_o`, `nt_we_o` and `pal_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Requested address, upper two bits ignored |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| mirror_mode_i | input | 3 | Nametable mirroring mode from the cartridge |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| cart_addr_o | output | 13 | Cartridge address |
| cart_rd_o | output | 1 | Cartridge read strobe |
| cart_wr_o | output | 1 | Cartridge write strobe |
| cart_wdata_o | output | 8 | Cartridge write data |
| cart_rdata_i | input | 8 | Cartridge read data, combinational from the address |
| nt_addr_o | output | 11 | Nametable RAM index |
| nt_we_o | output | 1 | Nametable RAM write strobe |
| pal_addr_o | output | 5 | Palette RAM index after aliasing |
| pal_we_o | output | 1 | Palette RAM write strobe |

## Verification
The assertions assume that `rd_i` and `wr_i` are never high in the same cycle. They also assume that `mirror_mode_i` stays steady for the length of an access. The directed tasks hold each strobe for exactly one cycle and clear it before the next access starts. They change the mirroring mode only between groups of accesses. The cartridge model in the bench returns data that is a fixed function of `cart_addr_o`, and it settles within the strobe cycle, which is what R3 relies on.

// File: rtl/vmem_decoder.sv
module vmem_decoder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [2:0]    mirror_mode_i,
  output logic [DW-1:0] rdata_o,
  output logic [12:0]   cart_addr_o,
  output logic          cart_rd_o,
  output logic          cart_wr_o,
  output logic [DW-1:0] cart_wdata_o,
  input  logic [DW-1:0] cart_rdata_i,
  output logic [10:0]   nt_addr_o,
  output logic          nt_we_o,
  output logic [4:0]    pal_addr_o,
  output logic          pal_we_o
);
  localparam int NT_DEPTH  = 2048;
  localparam int PAL_DEPTH = 32;

  logic [13:0] a;
  logic        unused_hi;
  logic        in_cart, in_pal, in_nt;
  logic [2:0]  mode_eff;
  logic [1:0]  quad, page;

  assign a         = addr_i[13:0];
  assign unused_hi = ^addr_i[15:14];
  assign in_cart   = ~a[13];
  assign in_pal    = a[13] & (a[12:8] == 5'h1F);
  assign in_nt     = a[13] & ~in_pal;
  assign mode_eff  = (mirror_mode_i > 3'd4) ? 3'd0 : mirror_mode_i;
  assign quad      = a[11:10];

  always_comb begin
    case (mode_eff)
      3'd0:    page = {1'b0, quad[1]};
      3'd1:    page = {1'b0, quad[0]};
      3'd2:    page = 2'd0;
      3'd3:    page = 2'd1;
      default: page = quad;
    endcase
  end

  assign cart_addr_o  = a[12:0];
  assign cart_wdata_o = wdata_i;
  assign cart_rd_o    = rd_i & in_cart;
  assign cart_wr_o    = wr_i & in_cart;
  assign nt_addr_o    = {page[0], a[9:0]};
  assign nt_we_o      = wr_i & in_nt;
  assign pal_addr_o   = (a[4] && a[1:0] == 2'b00) ? {1'b0, a[3:0]} : a[4:0];
  assign pal_we_o     = wr_i & in_pal;

  logic [DW-1:0] nt_mem  [NT_DEPTH];
  logic [DW-1:0] pal_mem [PAL_DEPTH];
  logic [DW-1:0] nt_q, pal_q, cart_q;
  logic [1:0]    src_q;

  always_ff @(posedge clk) begin
    if (nt_we_o) nt_mem[nt_addr_o] <= wdata_i;
    if (rd_i && in_nt) nt_q <= nt_mem[nt_addr_o];
  end

  always_ff @(posedge clk) begin
    if (pal_we_o) pal_mem[pal_addr_o] <= wdata_i;
    if (rd_i && in_pal) pal_q <= pal_mem[pal_addr_o];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 2'd0;
      cart_q <= '0;
    end else if (rd_i) begin
      src_q <= in_pal ? 2'd2 : (in_nt ? 2'd1 : 2'd0);
      if (in_cart) cart_q <= cart_rdata_i;
    end
  end

  assign rdata_o = (src_q == 2'd2) ? pal_q : (src_q == 2'd1) ? nt_q : cart_q;

  // input contract: one strobe at a time
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_i && wr_i));

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cart_wr_o, nt_we_o, pal_we_o}));

  // R5
  pal_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we_o |-> !(pal_addr_o[4] && pal_addr_o[1:0] == 2'b00));

  // R7
  single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_we_o && mirror_mode_i == 3'd2) |-> !nt_addr_o[10]);

  // R7
  single_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_we_o && mirror_mode_i == 3'd3) |-> nt_addr_o[10]);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !wr_i) |-> !(cart_rd_o || cart_wr_o || nt_we_o || pal_we_o));
endmodule

// File: tb/vmem_decoder_tb_top.sv
module vmem_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  mirror_mode_i = '0;
  logic [7:0]  rdata_o, cart_wdata_o, cart_rdata_i;
  logic [12:0] cart_addr_o;
  logic        cart_rd_o, cart_wr_o, nt_we_o, pal_we_o;
  logic [10:0] nt_addr_o;
  logic [4:0]  pal_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // snapshots taken inside the strobe cycle
  logic [12:0] s_caddr;
  logic        s_crd, s_cwr, s_ntwe, s_palwe;
  logic [7:0]  s_cwd;
  logic [10:0] s_ntaddr;
  logic [4:0]  s_paladdr;

  always #2.5 clk = ~clk;

  assign cart_rdata_i = cart_addr_o[7:0] ^ {3'b000, cart_addr_o[12:8]} ^ 8'hA5;

  vmem_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .mirror_mode_i(mirror_mode_i), .rdata_o(rdata_o),
    .cart_addr_o(cart_addr_o), .cart_rd_o(cart_rd_o), .cart_wr_o(cart_wr_o),
    .cart_wdata_o(cart_wdata_o), .cart_rdata_i(cart_rdata_i),
    .nt_addr_o(nt_addr_o), .nt_we_o(nt_we_o), .pal_addr_o(pal_addr_o),
    .pal_we_o(pal_we_o)
  );

  function automatic logic [7:0] cart_model(input logic [12:0] ca);
    return ca[7:0] ^ {3'b000, ca[12:8]} ^ 8'hA5;
  endfunction

  function automatic int ref_page(input logic [2:0] m, input int q);
    int mm = (m > 3'd4) ? 0 : int'(m);
    case (mm)
      0: return (q >= 2) ? 1 : 0;
      1: return q % 2;
      2: return 0;
      3: return 1;
      default: return q;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_caddr = cart_addr_o; s_crd = cart_rd_o; s_cwr = cart_wr_o; s_cwd = cart_wdata_o;
    s_ntwe = nt_we_o; s_palwe = pal_we_o; s_ntaddr = nt_addr_o; s_paladdr = pal_addr_o;
  endtask

  task automatic do_write(input logic [15:0] ad, input logic [7:0] d);
    @(negedge clk);
    addr_i = ad; wdata_i = d; wr_i = 1'b1;
    #1 snap();
    @(posedge clk);
    #1 wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] ad, output logic [7:0] d);
    @(negedge clk);
    addr_i = ad; rd_i = 1'b1;
    #1 snap();
    @(posedge clk);
    #1 rd_i = 1'b0;
    @(negedge clk);
    d = rdata_o;
  endtask

  task automatic t_reset();
    check("R10 rdata after reset", rdata_o, 0);
    check("R10 idle strobes", {cart_rd_o, cart_wr_o, nt_we_o, pal_we_o}, 0);
  endtask

  task automatic t_cart();
    logic [7:0] d;
    do_write(16'h1234, 8'h5A);
    check("R2 cart_wr", s_cwr, 1);
    check("R2 cart_addr", s_caddr, 13'h1234);
    check("R2 cart_wdata", s_cwd, 8'h5A);
    check("R2 no ram write", {s_ntwe, s_palwe}, 0);
    do_read(16'h0ABC, d);
    check("R2 cart_rd", s_crd, 1);
    check("R3 cart read data", d, cart_model(13'h0ABC));
    do_read(16'hC123, d);
    check("R1 masked cart addr", s_caddr, 13'h0123);
    check("R1 masked cart data", d, cart_model(13'h0123));
  endtask

  task automatic t_palette();
    logic [7:0] d;
    do_write(16'h3F10, 8'h11);
    check("R5 alias index on write", s_paladdr, 5'h00);
    check("R4 pal write strobe", {s_palwe, s_ntwe, s_cwr}, 3'b100);
    do_read(16'h3F00, d);
    check("R5 0x10 aliases 0x00", d, 8'h11);
    do_write(16'h3F04, 8'h22);
    do_read(16'h3F14, d);
    check("R5 read 0x14 sees 0x04", d, 8'h22);
    do_write(16'h3F1C, 8'h66);
    check("R5 index 0x1C to 0x0C", s_paladdr, 5'h0C);
    do_write(16'h3F01, 8'h44);
    do_write(16'h3F11, 8'h33);
    check("R5 0x11 not aliased", s_paladdr, 5'h11);
    do_read(16'h3F01, d);
    check("R5 entry 0x01 intact", d, 8'h44);
    do_read(16'h3F11, d);
    check("R5 entry 0x11", d, 8'h33);
    do_write(16'h3FE5, 8'h77);
    do_read(16'h3F05, d);
    check("R4 0x3FE5 mirrors 0x3F05", d, 8'h77);
  endtask

  task automatic t_nt_mode(input logic [2:0] m);
    logic [7:0] d;
    int exp_v;
    string tag;
    tag = (m > 3'd4) ? "R8" : "R7";
    @(negedge clk) mirror_mode_i = m;
    for (int q = 0; q < 4; q++) begin
      do_write(16'h2000 + 16'(q * 16'h400) + 16'h055, 8'(int'(m) * 16 + q + 1));
      check({tag, " nt_addr"}, s_ntaddr, ((ref_page(m, q) % 2) << 10) + 'h055);
    end
    for (int q = 0; q < 4; q++) begin
      exp_v = 0;
      for (int k = 0; k < 4; k++)
        if (ref_page(m, k) % 2 == ref_page(m, q) % 2) exp_v = int'(m) * 16 + k + 1;
      do_read(16'h2000 + 16'(q * 16'h400) + 16'h055, d);
      check({tag, " nt readback"}, d, exp_v);
    end
  endtask

  task automatic t_nt_upper();
    logic [7:0] d;
    @(negedge clk) mirror_mode_i = 3'd2;
    do_write(16'h2123, 8'h9C);
    do_read(16'h3123, d);
    check("R6 0x3123 mirrors 0x2123", d, 8'h9C);
    do_write(16'h3EFF, 8'h3D);
    do_read(16'h2EFF, d);
    check("R6 0x3EFF mirrors 0x2EFF", d, 8'h3D);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    do_read(16'h3F00, d);
    repeat (3) @(negedge clk);
    check("R9 rdata holds without read", rdata_o, d);
    do_write(16'h3F00, 8'hEE);
    @(negedge clk);
    check("R9 rdata holds over write", rdata_o, d);
  endtask

  initial begin
    #100_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_cart();
    t_palette();
    for (int m = 0; m < 8; m++) t_nt_mode(3'(m));
    t_nt_upper();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule